// File: doc/BRIEF.md
# Variable-Length Instruction Format Decoder

This block sits behind the instruction fetch of a 24-bit accumulator machine whose instructions are one to four bytes long. Each cycle it may receive a four-byte window whose lowest byte is the first byte of an instruction. It names the operation and sorts the instruction into one of four formats:

- one-byte control codes;
- two-byte register-to-register forms;
- three-byte forms with a 12-bit displacement;
- four-byte forms with a 20-bit address.

For each instruction it reports the length in bytes, the register nibbles, the six addressing flag bits and the displacement or address. An opcode it does not know raises a flag.

The two long formats share one opcode space. The extension flag in the second byte alone decides between three and four bytes. One register stage gives a single cycle of latency. Fetch, effective-address arithmetic and execution belong to neighbouring blocks, which use the reported length to advance the program counter.

Top module: `instr_fmt_decoder`

## Requirements
- R1: After reset, `dec_valid`=0, `dec_illegal`=0, `dec_fmt`=0, `dec_len`=0, `dec_opc`=8'hFF, and every field output is 0.
- R2: `dec_valid` is high in the cycle after each cycle with `win_valid` high, and low in the cycle after each cycle with `win_valid` low. Decoded values appear together with `dec_valid`.
- R3: Byte 0 is `win_bytes[7:0]`. A byte 0 that is not a one-byte code is matched after masking with 8'hFC. The recognised two-byte codes are 90,94,98,9C,A0,A4,A8,AC,B0,B4,B8. The recognised long codes are 00,04,08,0C,18,1C,28,2C,30,34,38,3C,48,4C,50,54,D8,DC. `dec_opc` equals the masked byte.
- R4: One-byte codes C0, C4, C8, F0 and F8 are matched on the whole byte, with `dec_fmt`=1, `dec_len`=1 and `dec_opc` equal to byte 0. A byte such as C5 is not one of these codes, and no masked code matches it either.
- R5: For two-byte codes, `dec_fmt`=2 and `dec_len`=2. `dec_r1` is byte 1 bits 7:4 (`win_bytes[15:12]`) and `dec_r2` is byte 1 bits 3:0.
- R6: For long codes, `dec_flags` = {byte0[1], byte0[0], byte1[7], byte1[6], byte1[5], byte1[4]}, which is the order n,i,x,b,p,e. For every other format `dec_flags` is 0.
- R7: For a long code with byte1[4]=0: `dec_fmt`=3, `dec_len`=3, `dec_disp`={byte1[3:0], byte2} and `dec_addr`=0.
- R8: For a long code with byte1[4]=1: `dec_fmt`=4, `dec_len`=4, `dec_addr`={byte1[3:0], byte2, byte3} and `dec_disp`=0.
- R9: For an unmatched byte 0: `dec_illegal`=1, `dec_fmt`=0, `dec_len`=0, `dec_opc`=8'hFF, and all fields are 0. For any matched byte 0, `dec_illegal`=0.
- R10: In a cycle after `win_valid` is low, every output other than `dec_valid` keeps its previous value, whatever the window holds.
- R11: Fields that a format does not define are 0. The register nibbles are 0 outside format 2, and one-byte codes report all fields 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| win_valid | input | 1 | Window holds an instruction start this cycle |
| win_bytes | input | 32 | Instruction window, byte k at bits 8k+7:8k |
| dec_valid | output | 1 | Decoded outputs belong to a new instruction |
| dec_opc | output | 8 | Operation code, 8'hFF when unmatched |
| dec_fmt | output | 3 | Format 1..4, 0 when unmatched |
| dec_len | output | 3 | Instruction length in bytes, 0 when unmatched |
| dec_r1 | output | 4 | First register nibble |
| dec_r2 | output | 4 | Second register nibble |
| dec_flags | output | 6 | Addressing flags n,i,x,b,p,e (bit 5 down to 0) |
| dec_disp | output | 12 | Three-byte displacement |
| dec_addr | output | 20 | Four-byte address |
| dec_illegal | output | 1 | Byte 0 matched no known code |

## Verification
The assertions assume that `win_valid` and `win_bytes` are known values at every clock edge after reset. They also assume that a window marked valid starts on an instruction boundary, because the block cannot tell a misaligned byte from a real opcode.

The stimulus drives every byte-0 value. Each one is paired with second bytes that set and clear the extension and flag bits. Valid bursts are broken by idle cycles in which the window is inverted, so that the hold property is tested against bytes that would decode differently.

// File: rtl/instr_fmt_pkg.sv
package instr_fmt_pkg;

   localparam int BYTE_W  = 8;
   localparam int NIB_W   = BYTE_W / 2;
   localparam int DISP_W  = NIB_W + BYTE_W;
   localparam int FAR_W   = NIB_W + 2 * BYTE_W;
   localparam int FLAG_W  = 6;
   localparam int FMT_W   = 3;
   localparam logic [BYTE_W-1:0] OPC_MASK = 8'hFC;

   typedef enum logic [BYTE_W-1:0] {
      OP_LD_ACC     = 8'h00, OP_LD_IDX     = 8'h04, OP_LD_LINK    = 8'h08,
      OP_ST_ACC     = 8'h0C, OP_ADD        = 8'h18, OP_SUB        = 8'h1C,
      OP_CMP        = 8'h28, OP_IDX_STEP   = 8'h2C, OP_JMP_EQ     = 8'h30,
      OP_JMP_GT     = 8'h34, OP_JMP_LT     = 8'h38, OP_JMP        = 8'h3C,
      OP_CALL       = 8'h48, OP_RET        = 8'h4C, OP_LD_BYTE    = 8'h50,
      OP_ST_BYTE    = 8'h54, OP_RR_ADD     = 8'h90, OP_RR_SUB     = 8'h94,
      OP_RR_MUL     = 8'h98, OP_RR_DIV     = 8'h9C, OP_RR_CMP     = 8'hA0,
      OP_RR_SHL     = 8'hA4, OP_RR_SHR     = 8'hA8, OP_RR_MOVE    = 8'hAC,
      OP_SUPV_CALL  = 8'hB0, OP_RR_CLEAR   = 8'hB4, OP_RR_STEP    = 8'hB8,
      OP_TO_FLOAT   = 8'hC0, OP_TO_INT     = 8'hC4, OP_DEV_HALT   = 8'hC8,
      OP_DEV_READ   = 8'hD8, OP_DEV_WRITE  = 8'hDC, OP_DEV_START  = 8'hF0,
      OP_DEV_TEST   = 8'hF8, OP_NONE       = 8'hFF
   } opc_e;

   typedef enum logic [1:0] {
      CLS_BAD  = 2'd0,
      CLS_ONE  = 2'd1,
      CLS_TWO  = 2'd2,
      CLS_LONG = 2'd3
   } cls_e;

   typedef struct packed {
      opc_e               opc;
      logic [FMT_W-1:0]   fmt;
      logic [FMT_W-1:0]   len;
      logic [NIB_W-1:0]   r1;
      logic [NIB_W-1:0]   r2;
      logic [FLAG_W-1:0]  flags;
      logic [DISP_W-1:0]  disp;
      logic [FAR_W-1:0]   addr;
      logic               illegal;
   } dec_word_t;

   function automatic dec_word_t idle_word();
      dec_word_t w;
      w     = '0;
      w.opc = OP_NONE;
      return w;
   endfunction

endpackage

// File: rtl/ifd_opcode_lookup.sv
module ifd_opcode_lookup
   import instr_fmt_pkg::*;
(
   input  logic [BYTE_W-1:0] lead_byte,
   output opc_e              opc,
   output cls_e              cls
);

   logic [BYTE_W-1:0] masked;
   assign masked = lead_byte & OPC_MASK;

   always_comb begin
      opc = OP_NONE;
      cls = CLS_BAD;
      // one-byte codes win on an exact match before any masking
      case (lead_byte)
         OP_TO_FLOAT, OP_TO_INT, OP_DEV_HALT, OP_DEV_START, OP_DEV_TEST: begin
            opc = opc_e'(lead_byte);
            cls = CLS_ONE;
         end
         default: begin
            case (masked)
               OP_RR_ADD, OP_RR_SUB, OP_RR_MUL, OP_RR_DIV, OP_RR_CMP,
               OP_RR_SHL, OP_RR_SHR, OP_RR_MOVE, OP_SUPV_CALL,
               OP_RR_CLEAR, OP_RR_STEP: begin
                  opc = opc_e'(masked);
                  cls = CLS_TWO;
               end
               OP_LD_ACC, OP_LD_IDX, OP_LD_LINK, OP_ST_ACC, OP_ADD, OP_SUB,
               OP_CMP, OP_IDX_STEP, OP_JMP_EQ, OP_JMP_GT, OP_JMP_LT, OP_JMP,
               OP_CALL, OP_RET, OP_LD_BYTE, OP_ST_BYTE, OP_DEV_READ,
               OP_DEV_WRITE: begin
                  opc = opc_e'(masked);
                  cls = CLS_LONG;
               end
               default: begin
                  opc = OP_NONE;
                  cls = CLS_BAD;
               end
            endcase
         end
      endcase
   end

endmodule

// File: rtl/ifd_field_extract.sv
module ifd_field_extract
   import instr_fmt_pkg::*;
#(
   parameter int WIN_BYTES = 4
) (
   input  logic [WIN_BYTES*BYTE_W-1:0] window,
   input  opc_e                        opc,
   input  cls_e                        cls,
   output dec_word_t                   word
);

   localparam int EXT_BIT = NIB_W;

   logic [BYTE_W-1:0] lane [WIN_BYTES];

   for (genvar k = 0; k < WIN_BYTES; k++) begin : g_lane
      assign lane[k] = window[k*BYTE_W +: BYTE_W];
   end

   logic far_form;
   assign far_form = lane[1][EXT_BIT];

   always_comb begin
      word     = idle_word();
      word.opc = opc;
      case (cls)
         CLS_ONE: begin
            word.fmt = 3'd1;
            word.len = 3'd1;
         end
         CLS_TWO: begin
            word.fmt = 3'd2;
            word.len = 3'd2;
            word.r1  = lane[1][BYTE_W-1:NIB_W];
            word.r2  = lane[1][NIB_W-1:0];
         end
         CLS_LONG: begin
            word.flags = {lane[0][1:0], lane[1][BYTE_W-1:NIB_W]};
            if (far_form) begin
               word.fmt  = 3'd4;
               word.len  = 3'd4;
               word.addr = {lane[1][NIB_W-1:0], lane[2], lane[3]};
            end else begin
               word.fmt  = 3'd3;
               word.len  = 3'd3;
               word.disp = {lane[1][NIB_W-1:0], lane[2]};
            end
         end
         default: begin
            word.opc     = OP_NONE;
            word.illegal = 1'b1;
         end
      endcase
   end

endmodule

// File: rtl/ifd_out_stage.sv
module ifd_out_stage
   import instr_fmt_pkg::*;
#(
   parameter bit HOLD_ON_IDLE = 1'b1
) (
   input  logic      clk,
   input  logic      rst_n,
   input  logic      in_valid,
   input  dec_word_t in_word,
   output logic      out_valid,
   output dec_word_t out_word
);

   always_ff @(posedge clk) begin
      if (!rst_n) out_valid <= 1'b0;
      else        out_valid <= in_valid;
   end

   if (HOLD_ON_IDLE) begin : g_hold
      always_ff @(posedge clk) begin
         if (!rst_n)        out_word <= idle_word();
         else if (in_valid) out_word <= in_word;
      end
   end else begin : g_clear
      always_ff @(posedge clk) begin
         if (!rst_n) out_word <= idle_word();
         else        out_word <= in_valid ? in_word : idle_word();
      end
   end

endmodule

// File: rtl/instr_fmt_decoder.sv
module instr_fmt_decoder
   import instr_fmt_pkg::*;
#(
   parameter int WIN_BYTES    = 4,
   parameter bit HOLD_ON_IDLE = 1'b1
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        win_valid,
   input  logic [WIN_BYTES*BYTE_W-1:0] win_bytes,
   output logic                        dec_valid,
   output logic [BYTE_W-1:0]           dec_opc,
   output logic [FMT_W-1:0]            dec_fmt,
   output logic [FMT_W-1:0]            dec_len,
   output logic [NIB_W-1:0]            dec_r1,
   output logic [NIB_W-1:0]            dec_r2,
   output logic [FLAG_W-1:0]           dec_flags,
   output logic [DISP_W-1:0]           dec_disp,
   output logic [FAR_W-1:0]            dec_addr,
   output logic                        dec_illegal
);

   if (WIN_BYTES != 4) begin : g_bad_window
      $error("instr_fmt_decoder: window must hold exactly four bytes");
   end
   if (FAR_W != DISP_W + BYTE_W) begin : g_bad_widths
      $error("instr_fmt_decoder: address must extend displacement by one byte");
   end

   opc_e      lk_opc;
   cls_e      lk_cls;
   dec_word_t comb_word;
   dec_word_t reg_word;

   ifd_opcode_lookup u_lookup (
      .lead_byte (win_bytes[BYTE_W-1:0]),
      .opc       (lk_opc),
      .cls       (lk_cls)
   );

   ifd_field_extract #(.WIN_BYTES(WIN_BYTES)) u_fields (
      .window (win_bytes),
      .opc    (lk_opc),
      .cls    (lk_cls),
      .word   (comb_word)
   );

   ifd_out_stage #(.HOLD_ON_IDLE(HOLD_ON_IDLE)) u_stage (
      .clk       (clk),
      .rst_n     (rst_n),
      .in_valid  (win_valid),
      .in_word   (comb_word),
      .out_valid (dec_valid),
      .out_word  (reg_word)
   );

   assign dec_opc     = reg_word.opc;
   assign dec_fmt     = reg_word.fmt;
   assign dec_len     = reg_word.len;
   assign dec_r1      = reg_word.r1;
   assign dec_r2      = reg_word.r2;
   assign dec_flags   = reg_word.flags;
   assign dec_disp    = reg_word.disp;
   assign dec_addr    = reg_word.addr;
   assign dec_illegal = reg_word.illegal;

endmodule

// File: rtl/ifd_checker.sv
module ifd_checker (
   input logic        clk,
   input logic        rst_n,
   input logic        win_valid,
   input logic [31:0] win_bytes,
   input logic        dec_valid,
   input logic [7:0]  dec_opc,
   input logic [2:0]  dec_fmt,
   input logic [2:0]  dec_len,
   input logic [3:0]  dec_r1,
   input logic [3:0]  dec_r2,
   input logic [5:0]  dec_flags,
   input logic [11:0] dec_disp,
   input logic [19:0] dec_addr,
   input logic        dec_illegal
);

   a_r2_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
      win_valid |=> dec_valid);

   a_r2_idle_follows: assert property (@(posedge clk) disable iff (!rst_n)
      !win_valid |=> !dec_valid);

   a_r5_nibbles: assert property (@(posedge clk) disable iff (!rst_n)
      (dec_valid && dec_fmt == 3'd2) |->
         (dec_r1 == $past(win_bytes[15:12]) && dec_r2 == $past(win_bytes[11:8])));

   a_r6_flags_short: assert property (@(posedge clk) disable iff (!rst_n)
      (dec_valid && dec_fmt < 3'd3) |-> dec_flags == 6'd0);

   a_r8_far_ext: assert property (@(posedge clk) disable iff (!rst_n)
      (dec_valid && dec_fmt == 3'd4) |->
         ($past(win_bytes[12]) && dec_len == 3'd4 && dec_disp == 12'd0));

   a_r7_near_ext: assert property (@(posedge clk) disable iff (!rst_n)
      (dec_valid && dec_fmt == 3'd3) |->
         (!$past(win_bytes[12]) && dec_addr == 20'd0));

   a_r9_illegal_code: assert property (@(posedge clk) disable iff (!rst_n)
      dec_illegal |-> (dec_opc == 8'hFF && dec_len == 3'd0));

   a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !win_valid |=> ($stable(dec_opc) && $stable(dec_len) && $stable(dec_addr)
                      && $stable(dec_disp) && $stable(dec_flags)));

endmodule

bind instr_fmt_decoder ifd_checker u_chk (.*);

// File: tb/instr_fmt_decoder_tb.sv
module instr_fmt_decoder_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        win_valid = 1'b0;
   logic [31:0] win_bytes = '0;
   logic        dec_valid;
   logic [7:0]  dec_opc;
   logic [2:0]  dec_fmt;
   logic [2:0]  dec_len;
   logic [3:0]  dec_r1;
   logic [3:0]  dec_r2;
   logic [5:0]  dec_flags;
   logic [11:0] dec_disp;
   logic [19:0] dec_addr;
   logic        dec_illegal;

   int checks = 0;
   int failures = 0;

   always #5 clk = ~clk;

   instr_fmt_decoder u_dut (
      .clk(clk), .rst_n(rst_n), .win_valid(win_valid), .win_bytes(win_bytes),
      .dec_valid(dec_valid), .dec_opc(dec_opc), .dec_fmt(dec_fmt),
      .dec_len(dec_len), .dec_r1(dec_r1), .dec_r2(dec_r2),
      .dec_flags(dec_flags), .dec_disp(dec_disp), .dec_addr(dec_addr),
      .dec_illegal(dec_illegal)
   );

   task automatic chk(input string tag, input longint act, input longint exp);
      checks++;
      if (act != exp) begin
         failures++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // class: 0 unmatched, 1 one-byte, 2 register form, 3 long form
   function automatic int ref_class(input logic [7:0] b0);
      logic [7:0] m;
      m = b0 & 8'hFC;
      if (b0 == 8'hC0 || b0 == 8'hC4 || b0 == 8'hC8 || b0 == 8'hF0 || b0 == 8'hF8)
         return 1;
      if (m >= 8'h90 && m <= 8'hB8) return 2;
      case (m)
         8'h00, 8'h04, 8'h08, 8'h0C, 8'h18, 8'h1C, 8'h28, 8'h2C, 8'h30,
         8'h34, 8'h38, 8'h3C, 8'h48, 8'h4C, 8'h50, 8'h54, 8'hD8, 8'hDC: return 3;
         default: return 0;
      endcase
   endfunction

   logic [7:0]  e_opc;
   logic [2:0]  e_fmt, e_len;
   logic [3:0]  e_r1, e_r2;
   logic [5:0]  e_flags;
   logic [11:0] e_disp;
   logic [19:0] e_addr;
   logic        e_ill;

   task automatic compute(input logic [31:0] w);
      int c;
      logic [7:0] b0, b1, b2, b3;
      b0 = w[7:0]; b1 = w[15:8]; b2 = w[23:16]; b3 = w[31:24];
      c = ref_class(b0);
      e_opc = 8'hFF; e_fmt = 0; e_len = 0; e_r1 = 0; e_r2 = 0;
      e_flags = 0; e_disp = 0; e_addr = 0; e_ill = 0;
      case (c)
         1: begin e_opc = b0; e_fmt = 1; e_len = 1; end
         2: begin e_opc = b0 & 8'hFC; e_fmt = 2; e_len = 2; e_r1 = b1 >> 4; e_r2 = b1 % 16; end
         3: begin
            e_opc = b0 & 8'hFC;
            e_flags = (6'(b0 % 4) << 4) | 6'(b1 >> 4);
            if (b1[4]) begin
               e_fmt = 4; e_len = 4;
               e_addr = 20'((b1 % 16) * 65536 + b2 * 256 + b3);
            end else begin
               e_fmt = 3; e_len = 3;
               e_disp = 12'((b1 % 16) * 256 + b2);
            end
         end
         default: e_ill = 1;
      endcase
   endtask

   task automatic check_all(input string why, input int c);
      string fmt_tag;
      fmt_tag = (c == 1) ? "R4" : (c == 2) ? "R5" : (c == 0) ? "R9" :
                (e_fmt == 4) ? "R8" : "R7";
      chk({"R3 opcode ", why}, dec_opc, e_opc);
      chk({fmt_tag, " format ", why}, dec_fmt, e_fmt);
      chk({fmt_tag, " length ", why}, dec_len, e_len);
      chk({(c == 2) ? "R5" : "R11", " r1 ", why}, dec_r1, e_r1);
      chk({(c == 2) ? "R5" : "R11", " r2 ", why}, dec_r2, e_r2);
      chk({"R6 flags ", why}, dec_flags, e_flags);
      chk({"R7 disp ", why}, dec_disp, e_disp);
      chk({"R8 addr ", why}, dec_addr, e_addr);
      chk({"R9 illegal ", why}, dec_illegal, e_ill);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 reset valid", dec_valid, 0);
      chk("R1 reset illegal", dec_illegal, 0);
      chk("R1 reset opcode", dec_opc, 8'hFF);
      chk("R1 reset length", dec_len, 0);
      chk("R1 reset format", dec_fmt, 0);
      chk("R1 reset fields", {dec_r1, dec_r2, dec_flags, dec_disp, dec_addr}, 0);

      for (int b0 = 0; b0 < 256; b0++) begin
         for (int p = 0; p < 4; p++) begin
            logic [7:0] b1, b2, b3;
            logic [31:0] w;
            int c;
            case (p)
               0: b1 = 8'h00;
               1: b1 = 8'hFF;
               2: b1 = 8'h5A;
               default: b1 = 8'hA3;
            endcase
            b2 = 8'(b0) ^ 8'h3C;
            b3 = 8'(b0 + 8'h71);
            w = {b3, b2, b1, 8'(b0)};
            win_valid = 1'b1;
            win_bytes = w;
            compute(w);
            c = ref_class(8'(b0));
            @(negedge clk);
            chk("R2 valid after strobe", dec_valid, 1);
            check_all("sweep", c);
            if (((b0 * 4 + p) % 16) == 15) begin
               win_valid = 1'b0;
               win_bytes = ~w;
               @(negedge clk);
               chk("R10 valid low when idle", dec_valid, 0);
               check_all("R10 hold", c);
            end
         end
      end
      win_valid = 1'b0;

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule